// File: doc/BRIEF.md
# Dual-Input Clock Router with Loss-Triggered Output Gating

This block steers two incoming clocks onto four differential outputs arranged as two banks of two. A two-bit routing code picks which input feeds each bank. Each output has its own enable, and each input has an auto-disable switch. When that switch is on and the input reports loss of signal, every output fed from that input is forced quiet. A quiet output holds both legs low.

The control inputs (routing code, output enables, auto-disable switches) are captured on a control clock, and reset puts them at safe defaults. The loss flags act directly on the gating path. Each leg of every output is gated by its own latch, so gating changes land only on phase boundaries and never produce a shortened pulse. The captured enables are also returned on a readback port.

Top module: `clk_route_aod`

## Requirements
- R1: Routing code 0 drives all four outputs from input 0.
- R2: Routing code 1 drives bank 0 (outputs 0 and 1) from input 0 and bank 1 (outputs 2 and 3) from input 1.
- R3: Routing code 3 drives all four outputs from input 1.
- R4: Routing code 2 behaves exactly like code 0.
- R5: An active output's positive leg follows its source clock and its negative leg follows the inverted source. A quiet output holds both legs low.
- R6: Output i is quiet while bit i of the enable input has been captured low. Output bit i maps to output index i.
- R7: When an input's loss flag is high and its auto-disable bit (bit 0 for input 0, bit 1 for input 1) is captured high, every output fed from that input is quiet. Outputs fed from the other input are unaffected.
- R8: When an input's auto-disable bit is captured low, its loss flag has no effect on the outputs.
- R9: When the loss flag clears, the affected outputs resume toggling if their enables allow it.
- R10: During reset the captured controls read as all outputs enabled, both auto-disables on, and routing code 0. The readback port shows all ones during reset.
- R11: After reset the readback port equals the enable input captured at the previous control clock edge.
- R12: No output leg ever produces a high pulse shorter than the half period of its source clock when an enable or a loss flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that captures the routing code, enables and auto-disable bits |
| rst_n | input | 1 | Active-low reset of the captured controls |
| clk_in0 | input | 1 | Source clock 0 |
| clk_in1 | input | 1 | Source clock 1 |
| los0 | input | 1 | Loss-of-signal flag for source 0, high means lost |
| los1 | input | 1 | Loss-of-signal flag for source 1, high means lost |
| src_sel | input | 2 | Routing code (0, 1 and 3 as in R1 to R3; 2 treated as 0) |
| out_en | input | 4 | Per-output enable, bit i for output i |
| aod_en | input | 2 | Auto-disable switch per source |
| clk_out_p | output | 4 | Positive legs of the four outputs |
| clk_out_n | output | 4 | Negative legs of the four outputs |
| oe_rb | output | 4 | Readback of the captured output enables |

## Verification
The quiet-output assertions assume that the loss flags change only around control clock edges, not between them. They also assume that each source clock completes a full period within one control clock period, so that a condition held across two control edges has settled through both gating latches. The bench meets both assumptions: it drives the loss flags together with the other controls just after a falling control edge, and it runs the sources at periods of 6 ns and 14 ns against a 20 ns control clock. The runt-pulse monitor is paused for a few cycles around each routing change, because switching the source mux while the two clocks are in opposite phases is outside R12.

// File: rtl/clk_route_aod.sv
`timescale 1ns/100ps
module clk_route_aod #(
  parameter int NUM_OUT       = 4,
  parameter int OUTS_PER_BANK = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_in0,
  input  logic               clk_in1,
  input  logic               los0,
  input  logic               los1,
  input  logic [1:0]         src_sel,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [1:0]         aod_en,
  output logic [NUM_OUT-1:0] clk_out_p,
  output logic [NUM_OUT-1:0] clk_out_n,
  output logic [NUM_OUT-1:0] oe_rb
);
  localparam int NUM_BANK = NUM_OUT / OUTS_PER_BANK;

  logic [NUM_OUT-1:0]  oe_q;
  logic [1:0]          aod_q;
  logic [1:0]          sel_q;
  logic [1:0]          sel_eff;
  logic [1:0]          clk_v;
  logic [1:0]          kill;
  logic [NUM_BANK-1:0] bank_src;
  logic [NUM_OUT-1:0]  want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '1;
      aod_q <= 2'b11;
      sel_q <= 2'd0;
    end else begin
      oe_q  <= out_en;
      aod_q <= aod_en;
      sel_q <= src_sel;
    end
  end

  assign oe_rb   = oe_q;
  assign sel_eff = (sel_q == 2'd2) ? 2'd0 : sel_q;
  assign clk_v   = {clk_in1, clk_in0};
  assign kill    = {los1, los0} & aod_q;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    if (b >= NUM_BANK / 2) begin : g_hi
      assign bank_src[b] = sel_eff[0];
    end else begin : g_lo
      assign bank_src[b] = (sel_eff == 2'd3);
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam int B = i / OUTS_PER_BANK;
    logic src_clk;
    logic gate_p;
    logic gate_n;

    assign src_clk = clk_v[bank_src[B]];
    assign want[i] = oe_q[i] & ~kill[bank_src[B]];

    always_latch begin
      if (!src_clk) gate_p <= want[i];
    end

    always_latch begin
      if (src_clk) gate_n <= want[i];
    end

    assign clk_out_p[i] = src_clk & gate_p;
    assign clk_out_n[i] = ~src_clk & gate_n;

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_q[i] && $past(!oe_q[i])) |-> (!clk_out_p[i] && !clk_out_n[i]));

    // R7
    aod_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[bank_src[B]] && $past(kill[bank_src[B]]) && $stable(bank_src))
        |-> (!clk_out_p[i] && !clk_out_n[i]));
  end

  // R4
  invalid_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'd2) |-> (bank_src == '0));

  // R2
  split_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'd1) |-> (!bank_src[0] && bank_src[NUM_BANK-1]));

  // R10
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&oe_rb));

  // R11
  readback_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (oe_rb == $past(out_en)));

endmodule

// File: tb/sim_clk_route_aod.sv
`timescale 1ns/100ps
module sim_clk_route_aod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ci0 = 1'b0;
  logic ci1 = 1'b0;
  logic los0 = 1'b0;
  logic los1 = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [1:0] aod = 2'b11;
  logic [3:0] oe = 4'b0000;
  wire  [3:0] cp, cn, rb;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit runt_watch = 1'b0;
  bit done = 1'b0;

  logic [3:0] m_oe;
  logic [1:0] m_aod;
  int m_sel;

  clk_route_aod u0 (
    .clk(clk), .rst_n(rst_n), .clk_in0(ci0), .clk_in1(ci1),
    .los0(los0), .los1(los1), .src_sel(sel), .out_en(oe), .aod_en(aod),
    .clk_out_p(cp), .clk_out_n(cn), .oe_rb(rb)
  );

  always #10 clk = ~clk;
  initial begin #0.5; forever #3 ci0 = ~ci0; end
  initial begin #1.5; forever #7 ci1 = ~ci1; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oe = 4'b1111; m_aod = 2'b11; m_sel = 0;
    end else begin
      m_oe = oe; m_aod = aod;
      m_sel = (sel == 2'd2) ? 0 : int'(sel);
    end
  end

  function automatic int src_of(int bank);
    if (m_sel == 3) return 1;
    if (m_sel == 1) return bank;
    return 0;
  endfunction

  task automatic compare(string force_tag);
    for (int i = 0; i < 4; i++) begin
      int s; bit sc, l, en, ep, en_n;
      string tag;
      s  = src_of(i / 2);
      sc = (s == 1) ? ci1 : ci0;
      l  = (s == 1) ? los1 : los0;
      en = m_oe[i] && !(l && m_aod[s]);
      ep = en && sc;
      en_n = en && !sc;
      if (force_tag != "") tag = force_tag;
      else if (!m_oe[i]) tag = "R6";
      else if (l && m_aod[s]) tag = "R7";
      else if (l) tag = "R8";
      else if (m_sel == 1) tag = "R2";
      else if (m_sel == 3) tag = "R3";
      else tag = "R1";
      checks++;
      if (cp[i] !== ep || cn[i] !== en_n) begin
        errors++;
        $display("FAIL %s out%0d p/n actual %b%b expected %b%b at %0t",
                 tag, i, cp[i], cn[i], ep, en_n, $time);
      end
    end
    checks++;
    if (rb !== m_oe) begin
      errors++;
      $display("FAIL %s readback actual %b expected %b", rst_n ? "R11" : "R10", rb, m_oe);
    end
  endtask

  always @(negedge clk) if (checking) compare("");

  for (genvar g = 0; g < 4; g++) begin : g_mon
    realtime tp = 0.0;
    realtime tn = 0.0;
    always @(posedge cp[g]) tp = $realtime;
    always @(posedge cn[g]) tn = $realtime;
    always @(negedge cp[g]) if (runt_watch) begin
      checks++;
      if ($realtime - tp < 2.9) begin
        errors++;
        $display("FAIL R12 out%0d p pulse actual %0.1f expected >= 3.0", g, $realtime - tp);
      end
    end
    always @(negedge cn[g]) if (runt_watch) begin
      checks++;
      if ($realtime - tn < 2.9) begin
        errors++;
        $display("FAIL R12 out%0d n pulse actual %0.1f expected >= 3.0", g, $realtime - tn);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic spot(string tag);
    @(negedge clk);
    #0.2;
    compare(tag);
    #0.8;
  endtask

  task automatic route(logic [1:0] code);
    runt_watch = 1'b0;
    sel = code;
    cyc(3);
    runt_watch = 1'b1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(1);
    checking = 1'b1;
    cyc(2);
    spot("R10");
    rst_n = 1'b1;
    oe = 4'b1111;
    cyc(3);
    runt_watch = 1'b1;
    spot("R1");
    spot("R5");
    route(2'd1); spot("R2"); cyc(3);
    route(2'd3); spot("R3"); cyc(3);
    route(2'd2); spot("R4"); cyc(3);
    route(2'd1);
    oe = 4'b1010; cyc(2); spot("R6");
    oe = 4'b0101; cyc(2); spot("R6");
    oe = 4'b0000; cyc(2); spot("R5");
    oe = 4'b1111; cyc(2); spot("R11");
    los0 = 1'b1; cyc(2); spot("R7");
    los1 = 1'b1; cyc(2); spot("R7");
    los0 = 1'b0; cyc(2); spot("R9");
    route(2'd0); spot("R7");
    aod = 2'b00; los0 = 1'b1; cyc(2); spot("R8");
    route(2'd3); spot("R8");
    aod = 2'b10; cyc(2); spot("R7");
    los1 = 1'b0; cyc(2); spot("R9");
    los0 = 1'b0;
    for (int k = 0; k < 40; k++) begin
      route(2'($urandom_range(0, 3)));
      for (int j = 0; j < 6; j++) begin
        oe   = 4'($urandom);
        aod  = 2'($urandom);
        los0 = 1'($urandom);
        los1 = 1'($urandom);
        cyc(2);
      end
    end
    los0 = 1'b0; los1 = 1'b0; oe = 4'b1111;
    cyc(2); spot("R9");
    checking = 1'b0;
    runt_watch = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule